// File: doc/BRIEF.md
# Bit-Banged Two-Wire Bus Port

This peripheral lets software run a two-wire serial bus (one clock line, one data line) entirely by toggling bits. The start, stop and byte-transfer sequencing is done by software. The block decodes a 4 KiB register window on a simple synchronous bus, keeps a two-bit output latch and drives both lines as open-drain pads. It also passes the data line through a synchroniser so software can read it back.

Software uses two write offsets. One offset only sets latch bits and the other only clears them, so a line can be changed without a read-modify-write. A single read offset returns the clock latch bit together with the synchronised data-line level. Any access to an offset that is not defined sets a sticky error flag. A dedicated input clears that flag.

Top module: `bb2w_port`

## Requirements
- R1: While `rst_ni` is low and after its release, the latch is 2'b11, so both pad enables are 0 (lines released). `err_o` is 0 and `rdata_o` is 0.
- R2: A write (`req_i`=1, `we_i`=1) to offset 0x000 ORs `wdata_i[1:0]` into the latch at that clock edge. Write-data bits above bit 1 have no effect.
- R3: A write to offset 0x004 clears every latch bit whose `wdata_i` bit is 1, at that clock edge. Latch bits whose write-data bit is 0 are unchanged.
- R4: Latch bit 0 controls the clock line and latch bit 1 controls the data line. A pad enable is 1 (pulling the line low) exactly when its latch bit is 0.
- R5: A read (`req_i`=1, `we_i`=0) of offset 0x000 loads `rdata_o` at that edge. Bit 0 holds the clock latch bit, bit 1 holds the synchronised data-line level, and every other bit is zero.
- R6: `sda_i` passes through a two-flop synchroniser. A read at edge k returns the `sda_i` level that was captured at edge k-2.
- R7: A read or write at any offset other than 0x000 (read or write) or 0x004 (write only) sets `err_o` at that edge. An undefined read also loads `rdata_o` with all ones. The offset is compared at full 12-bit width, so unaligned offsets are undefined.
- R8: `err_o` is sticky: it stays 1 until `err_clr_i` is 1 at an edge. If an undefined access and `err_clr_i` occur at the same edge, the flag stays set.
- R9: Without a write to 0x000 or 0x004 the latch holds its value. Without a read, `rdata_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset within the 4 KiB window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | Sticky undefined-access flag |
| err_clr_i | input | 1 | Clears the error flag |
| sda_i | input | 1 | Data pad level |
| scl_oe_o | output | 1 | Clock pad pull-low enable |
| sda_oe_o | output | 1 | Data pad pull-low enable |

## Verification
A corrupted latch bit appears at a pad enable in the same cycle, and in bit 0 of the next read. A wrong synchroniser depth moves the data-line edge by one read cycle, which is seen when a read follows a level change by exactly two edges. A decode slip appears in three ways: a pad that should not move, a missing or spurious error flag, or all-ones read data. Each shows one edge after the access. The bench model is compared against every output on every cycle, so any of these shows up within one cycle.

// File: rtl/bb2w_pkg.sv
package bb2w_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_SET = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CLR = 12'h004;
  localparam int unsigned BIT_SCL = 0;
  localparam int unsigned BIT_SDA = 1;
  localparam logic [1:0] LAT_IDLE = 2'b11;
endpackage

// File: rtl/bb2w_decode.sv
module bb2w_decode
  import bb2w_pkg::*;
(
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              set_o,
  output logic              clr_o,
  output logic              rd_ok_o,
  output logic              rd_bad_o,
  output logic              bad_o
);
  logic hit_set, hit_clr;

  assign hit_set  = (addr_i == OFS_SET);
  assign hit_clr  = (addr_i == OFS_CLR);
  assign set_o    = req_i & we_i & hit_set;
  assign clr_o    = req_i & we_i & hit_clr;
  assign rd_ok_o  = req_i & ~we_i & hit_set;
  assign rd_bad_o = req_i & ~we_i & ~hit_set;
  assign bad_o    = rd_bad_o | (req_i & we_i & ~hit_set & ~hit_clr);
endmodule

// File: rtl/bb2w_latch.sv
module bb2w_latch
  import bb2w_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_i,
  input  logic       clr_i,
  input  logic [1:0] mask_i,
  output logic [1:0] lat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lat_o <= LAT_IDLE;
    else if (set_i) lat_o <= lat_o | mask_i;
    else if (clr_i) lat_o <= lat_o & ~mask_i;
  end

  // R2
  set_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> lat_o == ($past(lat_o) | $past(mask_i)));
  // R3
  clr_andn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> lat_o == ($past(lat_o) & ~$past(mask_i)));
  // R9
  lat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_i || clr_i) |=> $stable(lat_o));
endmodule

// File: rtl/bb2w_sync.sv
module bb2w_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[g] <= RST_VAL;
      else         chain[g] <= (g == 0) ? d_i : chain[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/bb2w_port.sv
module bb2w_port
  import bb2w_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  input  logic              err_clr_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  logic       set_en, clr_en, rd_ok, rd_bad, bad;
  logic [1:0] lat;
  logic       sda_s;

  bb2w_decode u_dec (
    .req_i, .we_i, .addr_i,
    .set_o(set_en), .clr_o(clr_en), .rd_ok_o(rd_ok), .rd_bad_o(rd_bad), .bad_o(bad)
  );

  bb2w_latch u_lat (
    .clk_i, .rst_ni, .set_i(set_en), .clr_i(clr_en),
    .mask_i(wdata_i[1:0]), .lat_o(lat)
  );

  bb2w_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i, .rst_ni, .d_i(sda_i), .q_o(sda_s)
  );

  // open drain: a 0 in the latch pulls the pad low
  assign scl_oe_o = ~lat[BIT_SCL];
  assign sda_oe_o = ~lat[BIT_SDA];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (rd_ok) begin
      rdata_o          <= '0;
      rdata_o[BIT_SCL] <= lat[BIT_SCL];
      rdata_o[BIT_SDA] <= sda_s;
    end else if (rd_bad) begin
      rdata_o <= '1;
    end
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_o <= 1'b0;
    else if (bad)       err_o <= 1'b1;
    else if (err_clr_i) err_o <= 1'b0;
  end

  // R7
  bad_rd_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i != OFS_SET) |=> (rdata_o == '1 && err_o));
  // R5
  rd_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFS_SET) |=> (rdata_o[DATA_W-1:2] == '0));
  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);
  // R9
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(rdata_o));
endmodule

// File: tb/bb2w_port_test.sv
module bb2w_port_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req = 0, we = 0, err_clr = 0;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        err, scl_oe, sda_oe;
  logic        ext_sda = 1;
  logic        sda_pad;

  int    vecs = 0, bad = 0;
  bit    done = 0;
  string tag = "R1";

  // reference state
  int          m_lat = 3, m_s1 = 1, m_s2 = 1, m_err = 0;
  logic [31:0] m_rd = 0;

  assign sda_pad = sda_oe ? 1'b0 : ext_sda;

  bb2w_port uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .err_clr_i(err_clr),
    .sda_i(sda_pad), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lat = 3; m_s1 = 1; m_s2 = 1; m_err = 0; m_rd = 0;
    end else begin
      int errset;
      errset = 0;
      if (req && we) begin
        if (addr == 12'h000)      m_lat = m_lat | int'(wdata[1:0]);
        else if (addr == 12'h004) m_lat = m_lat & ~int'(wdata[1:0]) & 3;
        else                      errset = 1;
      end else if (req) begin
        if (addr == 12'h000) m_rd = 32'(((m_s2 & 1) << 1) | (m_lat & 1));
        else begin m_rd = '1; errset = 1; end
      end
      if (errset) m_err = 1;
      else if (err_clr) m_err = 0;
      m_s2 = m_s1;
      m_s1 = int'(sda_pad);
    end
  end

  task automatic check(string req_t, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req_t, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check({tag, "/R4 scl_oe"}, 32'(scl_oe), 32'(!(m_lat & 1)));
    check({tag, "/R4 sda_oe"}, 32'(sda_oe), 32'(!(m_lat & 2)));
    check({tag, "/R8 err"},    32'(err),    32'(m_err));
    check({tag, "/R5 rdata"},  rdata,       m_rd);
  end

  task automatic acc(bit r, bit w, logic [11:0] a, logic [31:0] d, bit c, string t);
    @(negedge clk);
    tag = t; req = r; we = w; addr = a; wdata = d; err_clr = c;
  endtask

  task automatic idle(int n, string t);
    for (int i = 0; i < n; i++) acc(0, 0, 0, 0, 0, t);
  endtask

  initial begin
    #12;
    check("R1 reset scl_oe", 32'(scl_oe), 0);
    check("R1 reset sda_oe", 32'(sda_oe), 0);
    check("R1 reset err",    32'(err), 0);
    check("R1 reset rdata",  rdata, 0);
    @(negedge clk); rst_n = 1;
    idle(3, "R1");
    acc(1, 0, 12'h000, 0, 0, "R5");
    acc(1, 1, 12'h004, 1, 0, "R3");
    acc(1, 1, 12'h004, 2, 0, "R3");
    acc(1, 1, 12'h004, 0, 0, "R3");
    acc(1, 0, 12'h000, 0, 0, "R5");
    acc(1, 1, 12'h000, 32'hFFFF_FFFC, 0, "R2");
    acc(1, 1, 12'h000, 1, 0, "R2");
    acc(1, 1, 12'h000, 2, 0, "R2");
    idle(2, "R9");
    // synchroniser latency
    ext_sda = 0;
    acc(1, 0, 12'h000, 0, 0, "R6");
    acc(1, 0, 12'h000, 0, 0, "R6");
    acc(1, 0, 12'h000, 0, 0, "R6");
    ext_sda = 1;
    acc(1, 0, 12'h000, 0, 0, "R6");
    acc(1, 0, 12'h000, 0, 0, "R6");
    acc(1, 0, 12'h000, 0, 0, "R6");
    // undefined accesses
    acc(1, 1, 12'h008, 3, 0, "R7");
    idle(2, "R8");
    acc(0, 0, 0, 0, 1, "R8");
    acc(1, 0, 12'h004, 0, 0, "R7");
    acc(1, 0, 12'h001, 0, 1, "R8");
    acc(0, 0, 0, 0, 1, "R8");
    acc(1, 1, 12'hFFC, 0, 0, "R7");
    idle(1, "R9");
    acc(1, 1, 12'h000, 1, 1, "R8");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      case ($urandom % 5)
        0, 1: a = 12'h000;
        2:    a = 12'h004;
        3:    a = 12'h008;
        default: a = 12'hFFF;
      endcase
      ext_sda = 1'($urandom);
      acc(1'($urandom % 3 != 0), 1'($urandom), a, $urandom, 1'($urandom % 4 == 0), "R9");
    end
    idle(3, "R9");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule